// File: doc/BRIEF.md
# Pixel Window Transfer Engine

The engine takes a stream of 16-bit data words and places them into a rectangular window of an on-chip frame buffer that is addressed in bytes. A setup step is triggered in two ways: by a pulse on the source-select strobe, or by a data word that arrives while no transfer is pending. Setup checks the window corners, the input format code and the source select. It then works out the window width and height, the bytes per pixel, and how many 16-bit words the window will take. After that it emits one frame buffer write per accepted word. The write address walks along each row and steps down one screen row when the row is full.

When the final word of a window is written, the engine commits the window. It pulses `done` and grows a dirty rectangle so that the rectangle also covers the window. A display refresh reads the rectangle and then pulses `refresh`, which sets the rectangle back to empty.

Top module: `pwt_engine`

## Requirements
- R1: The format code sets the bytes per pixel (bpp) as follows: code 1 gives 2, codes 2 and 3 give 3, codes 6 and 7 give 4. Every other code is unsupported, and setup fails for it.
- R2: Setup fails when the source select is above 3, when the format is unsupported, when x end < x start, or when y end < y start. A word that fails setup is dropped and produces no write. A failed setup also leaves the dirty rectangle unchanged.
- R3: Width = x_end − x_start + 1 and height = y_end − y_start + 1. A window takes floor(bpp × width × height / 2) words, and it completes on the last of those words.
- R4: The first word is written at byte address (y_start × SCR_W + x_start) × bpp. Each later word is written 2 bytes further on. When the offset within the row reaches or passes width × bpp, the offset drops by width × bpp and the row base advances by SCR_W × bpp.
- R5: An accepted word appears on `fb_we`/`fb_addr`/`fb_wdata` in the cycle after the clock edge that sampled `data_vld`.
- R6: `done` is high for exactly one cycle, and that cycle is the one carrying the window's last write.
- R7: On commit, the dirty rectangle becomes the union of its old bounds and the window. The starts take the minimum and the exclusive ends take the maximum of start + size. It updates on the same edge as `done`.
- R8: At reset and after a `refresh`, the dirty rectangle is empty: x0 = SCR_W, y0 = SCR_H, x1 = 0, y1 = 0.
- R9: A successful `src_wr` setup restarts the transfer and discards any words still owed. A failed `src_wr` setup leaves a pending transfer untouched. A data word in the same cycle as `src_wr` is dropped.
- R10: When no transfer is pending, a data word runs setup and is used as the first word of the new window. A one-word window completes in that same cycle.
- R11: When `refresh` and a commit fall in the same cycle, the dirty rectangle is left equal to the committed window alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_x0 | input | CW | Window x start |
| win_y0 | input | CW | Window y start |
| win_x1 | input | CW | Window x end (inclusive) |
| win_y1 | input | CW | Window y end (inclusive) |
| fmt_code | input | 4 | Input format code |
| src_sel | input | 3 | Source select |
| src_wr | input | 1 | Source select strobe; runs setup |
| data_vld | input | 1 | Data word strobe |
| data_word | input | 16 | Data word |
| refresh | input | 1 | Display refresh consumed the dirty rectangle |
| fb_we | output | 1 | Frame buffer write enable |
| fb_addr | output | ADDR_W | Frame buffer byte address |
| fb_wdata | output | 16 | Frame buffer write data |
| done | output | 1 | Window committed pulse |
| dirty_x0 | output | CW+1 | Dirty rectangle x start |
| dirty_y0 | output | CW+1 | Dirty rectangle y start |
| dirty_x1 | output | CW+1 | Dirty rectangle x end (exclusive) |
| dirty_y1 | output | CW+1 | Dirty rectangle y end (exclusive) |

## Verification
Every result lags the clock edge that samples its stimulus by one register. The write, the done pulse and the new dirty bounds all become visible together, one cycle after the strobe. The same holds for the emptied rectangle after a refresh. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and reads the outputs on the next falling edge. Each check therefore lands in the cycle where its result is due, and a late or early result is caught. Rejected and dropped words are judged by the absence of `fb_we` in that same cycle.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
    // Bytes per pixel for each input format code; 0 marks an unsupported code.
    function automatic logic [2:0] fmt_bpp(input logic [3:0] code);
        case (code)
            4'd1:         return 3'd2;
            4'd2, 4'd3:   return 3'd3;
            4'd6, 4'd7:   return 3'd4;
            default:      return 3'd0;
        endcase
    endfunction
endpackage

// File: rtl/pwt_setup.sv
module pwt_setup #(
    parameter int CW     = 10,
    parameter int CNT_W  = 23,
    parameter int RB_W   = 13,
    parameter int ADDR_W = 19,
    parameter int SCR_W  = 320
) (
    input  logic [CW-1:0]     x0,
    input  logic [CW-1:0]     y0,
    input  logic [CW-1:0]     x1,
    input  logic [CW-1:0]     y1,
    input  logic [3:0]        fmt,
    input  logic [2:0]        src,
    output logic              ok,
    output logic [CW:0]       w,
    output logic [CW:0]       h,
    output logic [CNT_W-1:0]  words,
    output logic [RB_W-1:0]   row_bytes,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] stride
);
    import pwt_pkg::*;

    logic [2:0]       bpp;
    logic [CNT_W-1:0] total_bytes;

    always_comb begin
        bpp         = fmt_bpp(fmt);
        w           = {1'b0, x1} - {1'b0, x0} + 1'b1;
        h           = {1'b0, y1} - {1'b0, y0} + 1'b1;
        ok          = (src <= 3'd3) && (bpp != 3'd0) && (x1 >= x0) && (y1 >= y0);
        total_bytes = CNT_W'(bpp) * CNT_W'(w) * CNT_W'(h);
        words       = total_bytes >> 1;
        row_bytes   = RB_W'(bpp) * RB_W'(w);
        stride      = ADDR_W'(SCR_W) * ADDR_W'(bpp);
        base        = (ADDR_W'(y0) * ADDR_W'(SCR_W) + ADDR_W'(x0)) * ADDR_W'(bpp);
    end
endmodule

// File: rtl/pwt_addr_gen.sv
module pwt_addr_gen #(
    parameter int ADDR_W = 19,
    parameter int RB_W   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [RB_W-1:0]   rb_i,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] row_base;
        logic [ADDR_W-1:0] stride;
        logic [RB_W-1:0]   rb;
        logic [RB_W-1:0]   col;
    } walk_t;

    walk_t       eff, walk_d, walk_q;
    logic [RB_W:0] col_sum;

    always_comb begin
        eff = walk_q;
        if (load) begin
            eff.row_base = base_i;
            eff.stride   = stride_i;
            eff.rb       = rb_i;
            eff.col      = '0;
        end
        addr_o  = eff.row_base + ADDR_W'(eff.col);
        col_sum = {1'b0, eff.col} + (RB_W+1)'(2);
        walk_d  = eff;
        if (step) begin
            if (col_sum >= {1'b0, eff.rb}) begin
                walk_d.col      = RB_W'(col_sum - {1'b0, eff.rb});
                walk_d.row_base = eff.row_base + eff.stride;
            end else begin
                walk_d.col = RB_W'(col_sum);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    // The offset within a row always stays below the row length once a window is loaded.
    assert_col_in_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_q.rb != '0) |-> (walk_q.col < walk_q.rb));
endmodule

// File: rtl/pwt_dirty.sv
module pwt_dirty #(
    parameter int CW    = 10,
    parameter int SCR_W = 320,
    parameter int SCR_H = 240
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        merge,
    input  logic [CW:0] wx0,
    input  logic [CW:0] wy0,
    input  logic [CW:0] wx1,
    input  logic [CW:0] wy1,
    output logic [CW:0] dx0,
    output logic [CW:0] dy0,
    output logic [CW:0] dx1,
    output logic [CW:0] dy1
);
    typedef struct packed {
        logic [CW:0] x0;
        logic [CW:0] y0;
        logic [CW:0] x1;
        logic [CW:0] y1;
    } rect_t;

    localparam rect_t EMPTY = '{x0: (CW+1)'(SCR_W), y0: (CW+1)'(SCR_H), x1: '0, y1: '0};

    rect_t cur, rect_d, rect_q;

    always_comb begin
        cur    = clr ? EMPTY : rect_q;
        rect_d = cur;
        if (merge) begin
            rect_d.x0 = (wx0 < cur.x0) ? wx0 : cur.x0;
            rect_d.y0 = (wy0 < cur.y0) ? wy0 : cur.y0;
            rect_d.x1 = (wx1 > cur.x1) ? wx1 : cur.x1;
            rect_d.y1 = (wy1 > cur.y1) ? wy1 : cur.y1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rect_q <= EMPTY;
        else        rect_q <= rect_d;
    end

    assign dx0 = rect_q.x0;
    assign dy0 = rect_q.y0;
    assign dx1 = rect_q.x1;
    assign dy1 = rect_q.y1;

    assert_refresh_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !merge) |=> (dx0 == (CW+1)'(SCR_W) && dy0 == (CW+1)'(SCR_H) && dx1 == '0 && dy1 == '0));

    assert_union_covers_R7: assert property (@(posedge clk) disable iff (!rst_n)
        merge |=> (dx0 <= $past(wx0) && dy0 <= $past(wy0) && dx1 >= $past(wx1) && dy1 >= $past(wy1)));
endmodule

// File: rtl/pwt_engine.sv
module pwt_engine #(
    parameter int SCR_W = 320,
    parameter int SCR_H = 240,
    parameter int CW    = 10,
    localparam int ADDR_W = $clog2(SCR_W * SCR_H * 4),
    localparam int CNT_W  = 2 * CW + 3,
    localparam int RB_W   = CW + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     win_x0,
    input  logic [CW-1:0]     win_y0,
    input  logic [CW-1:0]     win_x1,
    input  logic [CW-1:0]     win_y1,
    input  logic [3:0]        fmt_code,
    input  logic [2:0]        src_sel,
    input  logic              src_wr,
    input  logic              data_vld,
    input  logic [15:0]       data_word,
    input  logic              refresh,
    output logic              fb_we,
    output logic [ADDR_W-1:0] fb_addr,
    output logic [15:0]       fb_wdata,
    output logic              done,
    output logic [CW:0]       dirty_x0,
    output logic [CW:0]       dirty_y0,
    output logic [CW:0]       dirty_x1,
    output logic [CW:0]       dirty_y1
);
    typedef struct packed {
        logic              pending;
        logic [CNT_W-1:0]  remaining;
        logic [CW:0]       wx0;
        logic [CW:0]       wy0;
        logic [CW:0]       wx1e;
        logic [CW:0]       wy1e;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       wdata;
        logic              done;
    } eng_t;

    eng_t st_d, st_q;

    logic              setup_ok;
    logic [CW:0]       su_w, su_h;
    logic [CNT_W-1:0]  su_words;
    logic [RB_W-1:0]   su_rb;
    logic [ADDR_W-1:0] su_base, su_stride, walk_addr;
    logic              load, accept, commit;
    logic [CNT_W-1:0]  rem_after;

    pwt_setup #(.CW(CW), .CNT_W(CNT_W), .RB_W(RB_W), .ADDR_W(ADDR_W), .SCR_W(SCR_W)) u_setup (
        .x0(win_x0), .y0(win_y0), .x1(win_x1), .y1(win_y1),
        .fmt(fmt_code), .src(src_sel),
        .ok(setup_ok), .w(su_w), .h(su_h), .words(su_words),
        .row_bytes(su_rb), .base(su_base), .stride(su_stride)
    );

    pwt_addr_gen #(.ADDR_W(ADDR_W), .RB_W(RB_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .load(load), .step(accept),
        .base_i(su_base), .stride_i(su_stride), .rb_i(su_rb), .addr_o(walk_addr)
    );

    pwt_dirty #(.CW(CW), .SCR_W(SCR_W), .SCR_H(SCR_H)) u_dirty (
        .clk(clk), .rst_n(rst_n), .clr(refresh), .merge(commit),
        .wx0(st_d.wx0), .wy0(st_d.wy0), .wx1(st_d.wx1e), .wy1(st_d.wy1e),
        .dx0(dirty_x0), .dy0(dirty_y0), .dx1(dirty_x1), .dy1(dirty_y1)
    );

    always_comb begin
        st_d      = st_q;
        st_d.we   = 1'b0;
        st_d.done = 1'b0;
        load      = 1'b0;
        accept    = 1'b0;
        commit    = 1'b0;
        rem_after = st_q.remaining;

        if (src_wr) begin
            // A setup strobe wins over a data word in the same cycle; that word is lost.
            if (setup_ok) begin
                load           = 1'b1;
                st_d.remaining = su_words;
            end
        end else if (data_vld) begin
            if (st_q.pending) begin
                accept    = 1'b1;
                rem_after = st_q.remaining - 1'b1;
            end else if (setup_ok) begin
                load      = 1'b1;
                accept    = 1'b1;
                rem_after = su_words - 1'b1;
            end
        end

        if (load) begin
            st_d.pending = 1'b1;
            st_d.wx0     = {1'b0, win_x0};
            st_d.wy0     = {1'b0, win_y0};
            st_d.wx1e    = {1'b0, win_x0} + su_w;
            st_d.wy1e    = {1'b0, win_y0} + su_h;
        end

        if (accept) begin
            st_d.we        = 1'b1;
            st_d.addr      = walk_addr;
            st_d.wdata     = data_word;
            st_d.remaining = rem_after;
            if (rem_after == '0) begin
                st_d.pending = 1'b0;
                st_d.done    = 1'b1;
                commit       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fb_we    = st_q.we;
    assign fb_addr  = st_q.addr;
    assign fb_wdata = st_q.wdata;
    assign done     = st_q.done;

    assert_done_with_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> fb_we);

    assert_write_from_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> ($past(data_vld) && !$past(src_wr)));

    assert_drop_on_bad_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (data_vld && !src_wr && !st_q.pending && !setup_ok) |=> !fb_we);

    assert_pending_owes_words_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pending |-> (st_q.remaining != '0));
endmodule

// File: tb/sim_pwt_engine.sv
module sim_pwt_engine;
    localparam int SCR_W  = 320;
    localparam int SCR_H  = 240;
    localparam int CW     = 10;
    localparam int ADDR_W = $clog2(SCR_W * SCR_H * 4);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CW-1:0]     win_x0 = '0, win_y0 = '0, win_x1 = '0, win_y1 = '0;
    logic [3:0]        fmt_code = 4'd1;
    logic [2:0]        src_sel = '0;
    logic              src_wr = 1'b0, data_vld = 1'b0, refresh = 1'b0;
    logic [15:0]       data_word = '0;
    logic              fb_we, done;
    logic [ADDR_W-1:0] fb_addr;
    logic [15:0]       fb_wdata;
    logic [CW:0]       dirty_x0, dirty_y0, dirty_x1, dirty_y1;

    pwt_engine #(.SCR_W(SCR_W), .SCR_H(SCR_H), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .win_x0(win_x0), .win_y0(win_y0), .win_x1(win_x1), .win_y1(win_y1),
        .fmt_code(fmt_code), .src_sel(src_sel), .src_wr(src_wr),
        .data_vld(data_vld), .data_word(data_word), .refresh(refresh),
        .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata), .done(done),
        .dirty_x0(dirty_x0), .dirty_y0(dirty_y0), .dirty_x1(dirty_x1), .dirty_y1(dirty_y1)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // Reference model state, built from the requirements.
    int m_words, m_sent, m_rb, m_stride, m_row, m_col;
    int m_x0, m_y0, m_x1e, m_y1e;
    int ex0 = SCR_W, ey0 = SCR_H, ex1 = 0, ey1 = 0;

    // Each entry: x0, y0, x1, y1 (10 bits each), format code (4 bits).
    localparam int NV = 6;
    localparam logic [43:0] VEC [NV] = '{
        {10'd2,  10'd1, 10'd4,  10'd2, 4'd1},
        {10'd10, 10'd5, 10'd11, 10'd5, 4'd3},
        {10'd0,  10'd0, 10'd0,  10'd1, 4'd6},
        {10'd7,  10'd3, 10'd9,  10'd3, 4'd2},
        {10'd5,  10'd8, 10'd5,  10'd8, 4'd1},
        {10'd3,  10'd2, 10'd4,  10'd3, 4'd7}
    };

    function automatic int bpp_of(input int f);
        if (f == 1) return 2;
        if (f == 2 || f == 3) return 3;
        if (f == 6 || f == 7) return 4;
        return 0;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_dirty(input string req);
        chk({req, " dirty_x0"}, dirty_x0, ex0);
        chk({req, " dirty_y0"}, dirty_y0, ey0);
        chk({req, " dirty_x1"}, dirty_x1, ex1);
        chk({req, " dirty_y1"}, dirty_y1, ey1);
    endtask

    task automatic model_restart();
        m_sent = 0;
        m_col  = 0;
        m_row  = (m_y0 * SCR_W + m_x0) * bpp_of(int'(fmt_code));
    endtask

    task automatic set_win(input int x0, input int y0, input int x1, input int y1, input int f);
        int b;
        @(negedge clk);
        win_x0 = CW'(x0); win_y0 = CW'(y0); win_x1 = CW'(x1); win_y1 = CW'(y1);
        fmt_code = 4'(f);
        b        = bpp_of(f);
        m_words  = (b * (x1 - x0 + 1) * (y1 - y0 + 1)) / 2;
        m_rb     = b * (x1 - x0 + 1);
        m_stride = SCR_W * b;
        m_x0 = x0; m_y0 = y0; m_x1e = x1 + 1; m_y1e = y1 + 1;
        model_restart();
    endtask

    task automatic clear_exp();
        ex0 = SCR_W; ey0 = SCR_H; ex1 = 0; ey1 = 0;
    endtask

    task automatic push(input logic [15:0] w, input bit exp_wr, input bit with_src, input bit with_ref);
        bit last;
        @(negedge clk);
        data_vld = 1'b1; data_word = w; src_wr = with_src; refresh = with_ref;
        @(negedge clk);
        data_vld = 1'b0; src_wr = 1'b0; refresh = 1'b0;
        chk("R5 write enable", fb_we, exp_wr);
        if (with_ref) clear_exp();
        if (exp_wr) begin
            last = (m_sent + 1 == m_words);
            chk("R4 address", fb_addr, m_row + m_col);
            chk("R5 data", fb_wdata, w);
            chk("R6 done", done, last);
            m_sent++;
            m_col += 2;
            if (m_col >= m_rb) begin
                m_col -= m_rb;
                m_row += m_stride;
            end
            if (last) begin
                ex0 = (m_x0 < ex0) ? m_x0 : ex0;
                ey0 = (m_y0 < ey0) ? m_y0 : ey0;
                ex1 = (m_x1e > ex1) ? m_x1e : ex1;
                ey1 = (m_y1e > ey1) ? m_y1e : ey1;
                model_restart();
            end
        end
    endtask

    task automatic src_pulse();
        @(negedge clk);
        src_wr = 1'b1;
        @(negedge clk);
        src_wr = 1'b0;
        chk("R9 no write on setup strobe", fb_we, 0);
    endtask

    task automatic do_refresh();
        @(negedge clk);
        refresh = 1'b1;
        @(negedge clk);
        refresh = 1'b0;
        clear_exp();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset fb_we", fb_we, 0);
        chk("R6 reset done", done, 0);
        chk_dirty("R8 reset");

        // Vector walk: R1 bpp, R3 word count, R4 addressing, R7 union, R10 auto setup.
        for (int i = 0; i < NV; i++) begin
            set_win(int'(VEC[i][43:34]), int'(VEC[i][33:24]), int'(VEC[i][23:14]),
                    int'(VEC[i][13:4]), int'(VEC[i][3:0]));
            chk("R1 supported format", (m_words > 0), 1);
            for (int k = 0; k < m_words; k++)
                push(16'(i * 256 + k + 1), 1'b1, 1'b0, 1'b0);
            chk_dirty("R7 union");
        end
        @(negedge clk);
        chk("R6 done drops after one cycle", done, 0);

        do_refresh();
        chk_dirty("R8 refresh");

        // R1: unsupported format codes are rejected.
        foreach (VEC[i]) begin end
        for (int f = 0; f < 16; f++) begin
            if (bpp_of(f) == 0) begin
                set_win(1, 1, 2, 2, f);
                push(16'hdead, 1'b0, 1'b0, 1'b0);
            end
        end
        // R2: source select above 3, and reversed corners.
        set_win(1, 1, 2, 2, 1);
        src_sel = 3'd4;
        push(16'hbeef, 1'b0, 1'b0, 1'b0);
        src_sel = 3'd0;
        set_win(5, 1, 4, 1, 1);
        push(16'hbeef, 1'b0, 1'b0, 1'b0);
        set_win(1, 6, 2, 5, 1);
        push(16'hbeef, 1'b0, 1'b0, 1'b0);
        chk_dirty("R2 rejected leaves dirty");

        // R9: restart mid-transfer with a new window.
        set_win(0, 0, 2, 1, 1);
        src_pulse();
        push(16'h1111, 1'b1, 1'b0, 1'b0);
        push(16'h2222, 1'b1, 1'b0, 1'b0);
        set_win(20, 10, 21, 10, 6);
        src_pulse();
        for (int k = 0; k < 4; k++)
            push(16'(16'h3000 + k), 1'b1, 1'b0, 1'b0);
        chk_dirty("R9 restart");

        // R9: a failed strobe keeps the pending transfer.
        set_win(0, 4, 1, 4, 1);
        src_pulse();
        push(16'h4444, 1'b1, 1'b0, 1'b0);
        src_sel = 3'd5;
        src_pulse();
        src_sel = 3'd0;
        push(16'h5555, 1'b1, 1'b0, 1'b0);
        chk_dirty("R9 failed strobe");

        // R9: data word coinciding with the strobe is dropped.
        set_win(0, 6, 1, 6, 1);
        push(16'h6666, 1'b0, 1'b1, 1'b0);
        push(16'h7777, 1'b1, 1'b0, 1'b0);
        push(16'h8888, 1'b1, 1'b0, 1'b0);
        chk_dirty("R9 coincident word");

        // R11 and R10: one-word window committing alongside refresh.
        set_win(30, 20, 30, 20, 1);
        push(16'h9999, 1'b1, 1'b0, 1'b1);
        chk_dirty("R11 refresh with commit");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule